// File: doc/BRIEF.md
# Suspend Memory Retention Controller

This block decides how external DRAM keeps its contents while the memory-controller chip sits in suspend. On a suspend request it latches a retention method and holds it for the whole suspend period. The method comes from three configuration inputs: a low-power refresh enable, a self-refresh select and a flag saying the attached memory is SDRAM. The three methods are no refresh, DRAM self refresh, and low-frequency refresh paced by a slow real-time clock.

While suspended, the block withdraws the enable of every general pad and gates off the general inputs. The refresh pads stay driven only while slow-clock refresh is in use. Once enough slow-clock periods have passed, the block tells the system that the fast clock may be stopped. On release it waits for the PLL to report lock. If self refresh was in use, it then issues a self-refresh exit command. Only after that are the pads restored. The hard reset input is asynchronous and returns the block to full-on at any time.

Top module: `susp_retain`

## Requirements
- R1: With the low-power refresh enable at 0, a suspend selects no refresh (ret_mode = 0). No refresh strobe and no self-refresh command is issued, and the refresh pad enable stays at 0 throughout suspend.
- R2: With the enable at 1, the self-refresh select at 1 and non-SDRAM memory, suspend selects self refresh (ret_mode = 1). Exactly one sr_enter pulse, one cycle wide, follows entry.
- R3: With the enable at 1, the select at 0 and non-SDRAM memory, suspend selects low-frequency refresh (ret_mode = 2). One ref_strobe pulse is issued per rising edge of rtc_in, after a two-flop synchronizer. The refresh pad enable stays at 1.
- R4: When mem_sdram is 1, suspend always selects no refresh (ret_mode = 0), whatever the other two bits are.
- R5: From the cycle after susp_req is sampled high, pad_oe and in_gate are 0 until suspend is fully exited. ref_pad_oe is 1 in full-on, and in suspend it is 1 only for low-frequency refresh.
- R6: clk_stop_ok rises only while suspended, and only after STOP_EDGES synchronized rtc_in rising edges have been seen since entry. It falls as soon as susp_req is released.
- R7: After susp_req is released, pad_oe stays 0 until pll_lock has been sampled high.
- R8: The retention method is latched on entry. Changes to the three configuration inputs during suspend do not change ret_mode or the refresh behaviour.
- R9: When leaving self refresh, sr_exit pulses for one cycle after lock. pad_oe returns in the following cycle.
- R10: With hrst_n low, the block is asynchronously in full-on: pad_oe = 1, in_gate = 1, ret_mode = 0, and no strobe, command or clk_stop_ok is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| susp_req | input | 1 | Suspend request, held high for the suspend period |
| lp_ref_on | input | 1 | Keep refreshing during suspend |
| sr_sel | input | 1 | 1 selects self refresh, 0 selects slow-clock refresh |
| mem_sdram | input | 1 | Attached memory is SDRAM |
| rtc_in | input | 1 | Slow real-time clock, asynchronous |
| pll_lock | input | 1 | PLL relocked and ready |
| pad_oe | output | 1 | Enable for general output and bidirectional pads |
| in_gate | output | 1 | 1 lets general inputs through |
| ref_pad_oe | output | 1 | Enable for refresh-related pads |
| ref_strobe | output | 1 | Low-frequency refresh command pulse |
| sr_enter | output | 1 | Self-refresh entry command pulse |
| sr_exit | output | 1 | Self-refresh exit command pulse |
| clk_stop_ok | output | 1 | Fast clock may be stopped |
| ret_mode | output | 2 | Latched method: 0 none, 1 self refresh, 2 slow-clock refresh |

## Verification
A wrong latched method shows on ret_mode in the first cycle of suspend. It also shows as a wrong count of strobes or commands by the end of that suspend. A stuck or miscounted slow-clock counter moves the rise of clk_stop_ok by at least one slow-clock pulse. A skipped lock wait or a skipped exit command makes pad_oe return one or more cycles early. Every one of these is visible within a single suspend and release sequence, so the sweep over all eight configurations exposes each of them.

// File: rtl/susp_retain.sv
module susp_retain #(
  parameter int STOP_EDGES = 2
) (
  input  logic       clk,
  input  logic       hrst_n,
  input  logic       susp_req,
  input  logic       lp_ref_on,
  input  logic       sr_sel,
  input  logic       mem_sdram,
  input  logic       rtc_in,
  input  logic       pll_lock,
  output logic       pad_oe,
  output logic       in_gate,
  output logic       ref_pad_oe,
  output logic       ref_strobe,
  output logic       sr_enter,
  output logic       sr_exit,
  output logic       clk_stop_ok,
  output logic [1:0] ret_mode
);
  localparam int CW = $clog2(STOP_EDGES + 1);
  localparam logic [1:0] M_NONE = 2'd0, M_SELF = 2'd1, M_SLOW = 2'd2;

  typedef enum logic [2:0] {S_FULL, S_SRIN, S_SUSP, S_LOCK, S_SROUT} st_t;

  st_t           st;
  logic [1:0]    mode_q, mode_d;
  logic [2:0]    rsync;
  logic [CW-1:0] hold_cnt;
  logic          rise, slow_act;

  assign rise   = rsync[1] & ~rsync[2];
  assign mode_d = (!lp_ref_on || mem_sdram) ? M_NONE : (sr_sel ? M_SELF : M_SLOW);

  always_ff @(posedge clk or negedge hrst_n)
    if (!hrst_n) rsync <= '0;
    else         rsync <= {rsync[1:0], rtc_in};

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      st     <= S_FULL;
      mode_q <= M_NONE;
    end else begin
      case (st)
        S_FULL:  if (susp_req) begin
                   mode_q <= mode_d;
                   st     <= (mode_d == M_SELF) ? S_SRIN : S_SUSP;
                 end
        S_SRIN:  st <= S_SUSP;
        S_SUSP:  if (!susp_req) st <= S_LOCK;
        S_LOCK:  if (pll_lock) st <= (mode_q == M_SELF) ? S_SROUT : S_FULL;
        default: st <= S_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge hrst_n)
    if (!hrst_n)                     hold_cnt <= '0;
    else if (st == S_FULL)           hold_cnt <= '0;
    else if (rise && (st == S_SRIN || st == S_SUSP) && hold_cnt != CW'(STOP_EDGES))
                                     hold_cnt <= hold_cnt + 1'b1;

  assign slow_act    = (mode_q == M_SLOW) && (st == S_SUSP || st == S_LOCK);
  assign pad_oe      = (st == S_FULL);
  assign in_gate     = (st == S_FULL);
  assign ref_pad_oe  = (st == S_FULL) || slow_act;
  assign ref_strobe  = slow_act && rise;
  assign sr_enter    = (st == S_SRIN);
  assign sr_exit     = (st == S_SROUT);
  assign clk_stop_ok = (st == S_SUSP) && (hold_cnt == CW'(STOP_EDGES));
  assign ret_mode    = mode_q;

  a_r5_pads_drop_on_req: assert property (@(posedge clk) disable iff (!hrst_n)
    $fell(pad_oe) |-> $past(susp_req));
  a_r6_stop_only_in_susp: assert property (@(posedge clk) disable iff (!hrst_n)
    $rose(clk_stop_ok) |-> !$past(pad_oe) && susp_req);
  a_r7_lock_before_pads: assert property (@(posedge clk) disable iff (!hrst_n)
    $rose(pad_oe) |-> $past(pll_lock) || $past(sr_exit));
  a_r9_exit_before_pads: assert property (@(posedge clk) disable iff (!hrst_n)
    $rose(pad_oe) && ret_mode == M_SELF |-> $past(sr_exit));
  a_r8_mode_held: assert property (@(posedge clk) disable iff (!hrst_n)
    !pad_oe && $past(!pad_oe) |-> $stable(ret_mode));
  a_r3_strobe_with_pads: assert property (@(posedge clk) disable iff (!hrst_n)
    ref_strobe |-> ref_pad_oe && ret_mode == M_SLOW);
  a_r2_one_command: assert property (@(posedge clk) disable iff (!hrst_n)
    $onehot0({sr_enter, sr_exit, ref_strobe}));
  a_r2_enter_single: assert property (@(posedge clk) disable iff (!hrst_n)
    sr_enter |=> !sr_enter);
endmodule

// File: tb/sim_susp_retain.sv
module sim_susp_retain;
  logic clk = 0, hrst_n = 0;
  logic susp_req = 0, lp_ref_on = 0, sr_sel = 0, mem_sdram = 0, rtc_in = 0, pll_lock = 0;
  logic pad_oe, in_gate, ref_pad_oe, ref_strobe, sr_enter, sr_exit, clk_stop_ok;
  logic [1:0] ret_mode;
  int total = 0, bad = 0, n_str = 0, n_ent = 0, n_ext = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  susp_retain #(.STOP_EDGES(2)) u0 (.*);

  always @(negedge clk) if (hrst_n) begin
    n_str += int'(ref_strobe);
    n_ent += int'(sr_enter);
    n_ext += int'(sr_exit);
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rtc_pulse();
    rtc_in = 1; repeat (4) @(negedge clk);
    rtc_in = 0; repeat (4) @(negedge clk);
  endtask

  task automatic run_cfg(int cfg);
    int lp = cfg & 1, sr = (cfg >> 1) & 1, sd = (cfg >> 2) & 1;
    int em = (lp == 0 || sd == 1) ? 0 : (sr == 1 ? 1 : 2);
    @(negedge clk);
    n_str = 0; n_ent = 0; n_ext = 0;
    lp_ref_on = lp[0]; sr_sel = sr[0]; mem_sdram = sd[0]; susp_req = 1;
    @(negedge clk);
    check("R5 pad_oe in suspend", pad_oe, 0);
    check("R5 in_gate in suspend", in_gate, 0);
    check(em == 0 ? (sd == 1 ? "R4 mode sdram" : "R1 mode none") : "R8 mode latched", ret_mode, em);
    check("R6 no early stop", clk_stop_ok, 0);
    lp_ref_on = ~lp_ref_on; sr_sel = ~sr_sel; mem_sdram = ~mem_sdram;
    rtc_pulse();
    check("R6 one edge not enough", clk_stop_ok, 0);
    rtc_pulse();
    check("R6 stop after edges", clk_stop_ok, 1);
    rtc_pulse();
    check("R8 mode held", ret_mode, em);
    check("R3 strobe count", n_str, em == 2 ? 3 : 0);
    check("R2 enter count", n_ent, em == 1 ? 1 : 0);
    check("R5 refresh pad in suspend", ref_pad_oe, em == 2 ? 1 : 0);
    susp_req = 0;
    repeat (3) @(negedge clk);
    check("R6 stop falls on release", clk_stop_ok, 0);
    check("R7 pads wait for lock", pad_oe, 0);
    pll_lock = 1;
    @(negedge clk);
    pll_lock = 0;
    if (em == 1) begin
      check("R9 exit pulse", sr_exit, 1);
      check("R9 pads off during exit", pad_oe, 0);
      @(negedge clk);
    end
    check("R7 pads back", pad_oe, 1);
    check("R7 inputs back", in_gate, 1);
    check("R9 exit count", n_ext, em == 1 ? 1 : 0);
    check("R1 no stray strobes", n_str, em == 2 ? 3 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset pad_oe", pad_oe, 1);
    check("R10 reset in_gate", in_gate, 1);
    check("R10 reset mode", ret_mode, 0);
    check("R10 reset stop", clk_stop_ok, 0);
    hrst_n = 1;
    for (int c = 0; c < 8; c++) run_cfg(c);
    @(negedge clk);
    lp_ref_on = 1; sr_sel = 0; mem_sdram = 0; susp_req = 1;
    @(negedge clk);
    rtc_pulse(); rtc_pulse();
    check("R6 stop before reset", clk_stop_ok, 1);
    hrst_n = 0; #1;
    check("R10 async pad_oe", pad_oe, 1);
    check("R10 async in_gate", in_gate, 1);
    check("R10 async mode", ret_mode, 0);
    check("R10 async stop", clk_stop_ok, 0);
    check("R10 async strobe", ref_strobe, 0);
    susp_req = 0;
    @(negedge clk); hrst_n = 1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule